// File: doc/BRIEF.md
# Oversampled Polyphase Channelizer

The block splits one stream of real two's complement samples into `NCH` complex frequency channels. A prototype low-pass filter of `NCH*TAPS` coefficients is split into `NCH` polyphase branches of `TAPS` coefficients each. The block produces a new output frame every `NCH/2` accepted samples. Channel centres therefore sit at half the channel width and neighbouring channels overlap, so the bank is oversampled by two. The coefficients come from a closed formula that is evaluated at elaboration time. No coefficient memory has to be loaded.

Each frame passes through two requantization points. The branch sums are shifted right by `fir_shift` and saturated to `MID_W` bits. A discrete transform then runs over the branches. Its result is shifted right by `out_shift` and saturated to `OUT_W` bits. The channels of a frame leave one per clock in ascending order, each with its channel index. A per-channel enable mask decides which channels are presented as valid, so only the channels that hold usable band are passed downstream. Sustained throughput needs the input valid strobe to be high on at most half of the cycles.

Top module: `osc_channelizer`

## Requirements
- R1: A sample enters the filter history only in a cycle where `in_valid` is 1. A frame completes on every `NCH/2`-th accepted sample, counted from reset. `in_data` is ignored while `in_valid` is 0.
- R2: Let s[0] be the newest accepted sample, s[1] the sample before it, and so on, with unfilled history taken as 0. Branch p sums h[p+t*NCH]*s[p+t*NCH] over t = 0..TAPS-1. The coefficients are h[i] = floor((i+1)*(L-i)*(2^(COEF_W-1)-1) / ((L/2)*(L/2+1))) with L = NCH*TAPS.
- R3: Each branch sum is arithmetically shifted right by `fir_shift`, as sampled in the completing cycle, and then saturated to the signed `MID_W`-bit range.
- R4: For channel k, the real part is the sum over p of v[p]*C[(p*k) mod NCH], where v[p] is the requantized branch value. The imaginary part is minus the sum of v[p]*S[(p*k) mod NCH]. C[j] and S[j] are cos(2*pi*j/NCH) and sin(2*pi*j/NCH), scaled by 2^(TW_W-1)-1 and rounded.
- R5: Frames are numbered from 0 after reset. In odd-numbered frames, the transform result of every odd-numbered channel is negated before output requantization.
- R6: The transform result is arithmetically shifted right by `out_shift` and saturated to the signed `OUT_W`-bit range. `out_shift` is captured when the frame completes.
- R7: For a frame that completes at clock edge e, channel k is presented on the outputs after edge e+1+k, with `out_ch` = k. The outputs step through k = 0..NCH-1 in ascending order.
- R8: Bit k of `ch_mask` enables channel k. It is captured when the frame completes. A disabled channel spends its cycle with `out_valid` at 0.
- R9: `out_sof` is 1 only together with the first valid channel of each frame and is 0 in every other cycle.
- R10: A frame that completes while an earlier frame is still being presented abandons the rest of the earlier frame. Its own channel 0 follows at the next edge.
- R11: Reset clears the history, the sample count and the frame number. It also holds `out_valid` and `out_sof` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Real input sample, two's complement |
| fir_shift | input | SH1_W | Right shift applied to the branch sums |
| out_shift | input | SH2_W | Right shift applied to the transform result |
| ch_mask | input | NCH | Channel enable, bit k for channel k |
| out_valid | output | 1 | Channel sample valid |
| out_sof | output | 1 | First valid channel of a frame |
| out_ch | output | CH_W | Channel index of the presented sample |
| out_re | output | OUT_W | Real part of the channel sample |
| out_im | output | OUT_W | Imaginary part of the channel sample |

## Verification
The bench builds the block with NCH = 8 and TAPS = 4, which gives 32 coefficients, a frame every four accepted samples and a 32-sample history. The history therefore fills within a few frames. A strobe that is high on every cycle overruns the eight-cycle presentation and forces the restart path. Both frame parities and all odd channels come up early. With the default data widths and small shifts, the range limits of both requantization points can be reached with an ordinary stepped-frequency sine.

// File: rtl/osc_channelizer.sv
module osc_channelizer #(
  parameter int NCH    = 32,
  parameter int TAPS   = 32,
  parameter int IN_W   = 8,
  parameter int COEF_W = 16,
  parameter int MID_W  = 12,
  parameter int TW_W   = 16,
  parameter int OUT_W  = 12,
  localparam int CH_W  = $clog2(NCH),
  localparam int V_W   = IN_W + COEF_W + $clog2(TAPS) + 1,
  localparam int A_W   = MID_W + TW_W + CH_W + 1,
  localparam int SH1_W = $clog2(V_W),
  localparam int SH2_W = $clog2(A_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [SH1_W-1:0]        fir_shift,
  input  logic [SH2_W-1:0]        out_shift,
  input  logic [NCH-1:0]          ch_mask,
  output logic                    out_valid,
  output logic                    out_sof,
  output logic [CH_W-1:0]         out_ch,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);
  localparam int L     = NCH * TAPS;
  localparam int HOP   = NCH / 2;
  localparam int HOP_W = $clog2(HOP);

  function automatic logic signed [COEF_W-1:0] coef(input int i);
    longint cmax, half;
    cmax = (longint'(1) <<< (COEF_W - 1)) - 1;
    half = longint'(L / 2);
    return COEF_W'((longint'(i + 1) * longint'(L - i) * cmax) / (half * (half + 1)));
  endfunction

  function automatic logic signed [TW_W-1:0] twid(input int k, input bit want_sin);
    longint th, c, s, tc, ts, v, tmax;
    int qd, r;
    r  = k % (NCH / 4);
    qd = k / (NCH / 4);
    th = (64'sd3373259426 * 2 * longint'(r)) / longint'(NCH);
    c  = longint'(1) <<< 30;
    s  = th;
    tc = c;
    ts = th;
    for (int n = 1; n < 10; n++) begin
      tc = -((((tc * th) >>> 30) * th) >>> 30) / longint'((2 * n - 1) * (2 * n));
      ts = -((((ts * th) >>> 30) * th) >>> 30) / longint'((2 * n) * (2 * n + 1));
      c  = c + tc;
      s  = s + ts;
    end
    case (qd)
      0:       v = want_sin ? s : c;
      1:       v = want_sin ? c : -s;
      2:       v = want_sin ? -s : -c;
      default: v = want_sin ? -c : s;
    endcase
    tmax = (longint'(1) <<< (TW_W - 1)) - 1;
    return TW_W'((v * tmax + (longint'(1) <<< 29)) >>> 30);
  endfunction

  function automatic logic signed [MID_W-1:0] sat_mid(input logic signed [V_W-1:0] x,
                                                       input logic [SH1_W-1:0] sh);
    logic signed [V_W-1:0] y;
    y = x >>> sh;
    if (y[V_W-1:MID_W-1] != {(V_W-MID_W+1){y[V_W-1]}})
      return {y[V_W-1], {(MID_W-1){~y[V_W-1]}}};
    return y[MID_W-1:0];
  endfunction

  function automatic logic signed [OUT_W-1:0] sat_out(input logic signed [A_W-1:0] x,
                                                       input logic [SH2_W-1:0] sh);
    logic signed [A_W-1:0] y;
    y = x >>> sh;
    if (y[A_W-1:OUT_W-1] != {(A_W-OUT_W+1){y[A_W-1]}})
      return {y[A_W-1], {(OUT_W-1){~y[A_W-1]}}};
    return y[OUT_W-1:0];
  endfunction

  logic signed [IN_W-1:0]   hist [L];
  logic signed [IN_W-1:0]   nb   [L];
  logic signed [COEF_W-1:0] h    [L];
  logic signed [TW_W-1:0]   cos_t [NCH];
  logic signed [TW_W-1:0]   sin_t [NCH];
  logic signed [MID_W-1:0]  vnext [NCH];
  logic signed [MID_W-1:0]  vq    [NCH];
  logic [HOP_W-1:0]         cnt;
  logic [CH_W-1:0]          ch;
  logic [NCH-1:0]           mask_q;
  logic [SH2_W-1:0]         osh_q;
  logic                     busy, first, par_q, fpar;
  logic signed [A_W-1:0]    are, aim, are_f, aim_f;
  logic                     frame_go;

  assign frame_go = in_valid && (cnt == HOP_W'(HOP - 1));

  for (genvar g = 0; g < L; g++) begin : g_tap
    localparam logic signed [COEF_W-1:0] HC = coef(g);
    assign h[g] = HC;
    if (g == 0) begin : g_new
      assign nb[g] = in_data;
    end else begin : g_old
      assign nb[g] = hist[g-1];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_tw
    localparam logic signed [TW_W-1:0] TC = twid(g, 1'b0);
    localparam logic signed [TW_W-1:0] TS = twid(g, 1'b1);
    assign cos_t[g] = TC;
    assign sin_t[g] = TS;
  end

  for (genvar p = 0; p < NCH; p++) begin : g_branch
    logic signed [V_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++)
        acc = acc + V_W'(h[p + t*NCH]) * V_W'(nb[p + t*NCH]);
    end
    assign vnext[p] = sat_mid(acc, fir_shift);
  end

  always_comb begin
    logic [CH_W-1:0] ix;
    are = '0;
    aim = '0;
    for (int p = 0; p < NCH; p++) begin
      ix  = CH_W'(p) * ch;
      are = are + A_W'(vq[p]) * A_W'(cos_t[ix]);
      aim = aim - A_W'(vq[p]) * A_W'(sin_t[ix]);
    end
  end

  assign are_f = (par_q && ch[0]) ? -are : are;
  assign aim_f = (par_q && ch[0]) ? -aim : aim;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) hist[i] <= '0;
      for (int p = 0; p < NCH; p++) vq[p] <= '0;
      cnt <= '0; ch <= '0; mask_q <= '0; osh_q <= '0;
      busy <= 1'b0; first <= 1'b0; par_q <= 1'b0; fpar <= 1'b0;
      out_valid <= 1'b0; out_sof <= 1'b0; out_ch <= '0; out_re <= '0; out_im <= '0;
    end else begin
      out_valid <= busy & mask_q[ch];
      out_sof   <= busy & mask_q[ch] & first;
      out_ch    <= ch;
      if (busy && mask_q[ch]) begin
        out_re <= sat_out(are_f, osh_q);
        out_im <= sat_out(aim_f, osh_q);
        first  <= 1'b0;
      end
      if (busy) begin
        ch <= ch + 1'b1;
        if (ch == CH_W'(NCH - 1)) busy <= 1'b0;
      end
      if (in_valid) begin
        hist[0] <= in_data;
        for (int i = 1; i < L; i++) hist[i] <= hist[i-1];
        cnt <= frame_go ? '0 : cnt + 1'b1;
      end
      if (frame_go) begin
        for (int p = 0; p < NCH; p++) vq[p] <= vnext[p];
        mask_q <= ch_mask;
        osh_q  <= out_shift;
        par_q  <= fpar;
        fpar   <= ~fpar;
        busy   <= 1'b1;
        ch     <= '0;
        first  <= 1'b1;
      end
    end
  end

  AST_IDLE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(cnt)); // R1
  AST_CH0_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst) frame_go |=> ##1 (out_ch == '0)); // R7
  AST_VALID_FROM_BUSY: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(busy)); // R7
  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst) out_sof |-> out_valid); // R9
  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst) out_sof |=> !out_sof); // R9
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !out_valid); // R11
endmodule

// File: tb/osc_channelizer_test.sv
`timescale 1ns/1ps
module osc_channelizer_test;
  localparam int NCH = 8, TAPS = 4, IN_W = 8, COEF_W = 16, MID_W = 12, TW_W = 16, OUT_W = 12;
  localparam int L = NCH * TAPS, HOP = NCH / 2, CH_W = 3, SH_W = 5;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic [SH_W-1:0] fir_shift = 5'd13, out_shift = 5'd18;
  logic [NCH-1:0] ch_mask = '1;
  logic out_valid, out_sof;
  logic [CH_W-1:0] out_ch;
  logic signed [OUT_W-1:0] out_re, out_im;

  osc_channelizer #(.NCH(NCH), .TAPS(TAPS), .IN_W(IN_W), .COEF_W(COEF_W), .MID_W(MID_W),
                    .TW_W(TW_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .fir_shift(fir_shift),
    .out_shift(out_shift), .ch_mask(ch_mask), .out_valid(out_valid), .out_sof(out_sof),
    .out_ch(out_ch), .out_re(out_re), .out_im(out_im));

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, sidx = 0;
  bit armed = 0;
  string tag = "R11";
  longint hist[$];
  longint tcos[NCH], tsin[NCH];
  int mcnt, mch, er[NCH], ei[NCH];
  bit mpar, mbusy, mfirst, e_vld, e_sof;
  bit [NCH-1:0] mmask;
  int e_ch, e_re, e_im;

  function automatic longint cf(int i);
    return (longint'(i + 1) * longint'(L - i) * 32767) / (longint'(L / 2) * longint'(L / 2 + 1));
  endfunction

  function automatic longint sat(longint x, int w);
    longint hi, lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    return (x > hi) ? hi : (x < lo) ? lo : x;
  endfunction

  task automatic check(string what, longint act, longint exp, longint tol);
    longint d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic build_frame();
    longint v, s, vq[NCH], re, im;
    for (int p = 0; p < NCH; p++) begin
      v = 0;
      for (int t = 0; t < TAPS; t++) begin
        s = (p + t*NCH < hist.size()) ? hist[p + t*NCH] : 0;
        v += cf(p + t*NCH) * s;
      end
      vq[p] = sat(v >>> fir_shift, MID_W);
    end
    for (int k = 0; k < NCH; k++) begin
      re = 0; im = 0;
      for (int p = 0; p < NCH; p++) begin
        re += vq[p] * tcos[(p*k) % NCH];
        im -= vq[p] * tsin[(p*k) % NCH];
      end
      if (mpar && (k % 2 == 1)) begin re = -re; im = -im; end
      er[k] = int'(sat(re >>> out_shift, OUT_W));
      ei[k] = int'(sat(im >>> out_shift, OUT_W));
    end
    mmask = ch_mask;
    mpar = ~mpar;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      hist.delete(); mcnt = 0; mpar = 0; mbusy = 0; mch = 0; mfirst = 0; e_vld = 0; e_sof = 0;
    end else begin
      e_vld = 0; e_sof = 0;
      if (mbusy) begin
        if (mmask[mch]) begin
          e_vld = 1; e_sof = mfirst; e_ch = mch; e_re = er[mch]; e_im = ei[mch]; mfirst = 0;
        end
        mch++;
        if (mch == NCH) mbusy = 0;
      end
      if (in_valid) begin
        hist.push_front(longint'(in_data));
        if (hist.size() > L) void'(hist.pop_back());
        mcnt++;
        if (mcnt == HOP) begin
          mcnt = 0; build_frame(); mbusy = 1; mch = 0; mfirst = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && armed) begin
      check("out_valid (R7 R8)", out_valid, e_vld, 0);
      check("out_sof (R9)", out_sof, e_sof, 0);
      if (e_vld && out_valid) begin
        check("out_ch (R7)", out_ch, e_ch, 0);
        check("out_re (R4 R5 R6)", out_re, e_re, 1);
        check("out_im (R4 R5 R6)", out_im, e_im, 1);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d exp=finish", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(int nsamp, int gap, real amp, real freq);
    real x;
    for (int i = 0; i < nsamp; i++) begin
      @(negedge clk);
      x = amp * $sin(2.0 * PI * freq * sidx);
      in_valid = 1'b1;
      in_data  = IN_W'(int'(sat(longint'(x), IN_W)));
      sidx++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = IN_W'(sidx * 37 + 11);
      end
    end
  endtask

  task automatic flush();
    for (int i = 0; i < NCH + 3; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = IN_W'(i * 91 + 5);
    end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      tcos[i] = longint'(int'($cos(2.0 * PI * i / NCH) * 32767.0));
      tsin[i] = longint'(int'($sin(2.0 * PI * i / NCH) * 32767.0));
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R11 reset state";
    check("out_valid after reset", out_valid, 0, 0);
    check("out_sof after reset", out_sof, 0, 0);
    armed = 1;

    tag = "R2 R4 R5 R7 stepped sine";
    run(48, 1, 100.0, 0.05);
    run(48, 1, 100.0, 0.125);
    run(48, 1, 100.0, 0.31);
    flush();

    tag = "R1 gapped strobe";
    run(64, 2, 90.0, 0.2);
    flush();

    tag = "R8 R9 partial mask";
    ch_mask = 8'b0110_1010;
    run(48, 1, 100.0, 0.07);
    ch_mask = 8'b0000_0000;
    run(16, 1, 100.0, 0.07);
    ch_mask = 8'b1000_0001;
    run(32, 1, 100.0, 0.4);
    flush();
    ch_mask = '1;

    tag = "R3 branch saturation";
    fir_shift = 5'd8;
    out_shift = 5'd20;
    run(48, 1, 127.0, 0.02);
    flush();

    tag = "R6 output saturation";
    fir_shift = 5'd13;
    out_shift = 5'd10;
    run(48, 1, 120.0, 0.15);
    flush();

    tag = "R10 frame restart";
    out_shift = 5'd18;
    run(64, 0, 100.0, 0.09);
    flush();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule